// File: doc/BRIEF.md
# Trusted-Module Interrupt Enable and Status Unit

This unit is the device-side interrupt logic of a trusted-module register interface. Four condition inputs (command ready, locality change, status valid and data available) are watched for rising edges and captured in sticky status bits. Software reads and clears those bits through a plain register port. It also programs per-source enables, a global enable, a trigger type and an 8-bit vector number. It can read a fixed capability word that reports what the unit supports.

The single interrupt pin combines the status bits with the enables. It then follows the programmed trigger type: a one-cycle pulse for the two edge types, or a held level for the two level types. The data-available source is qualified so that it only counts when status valid is true in the same cycle.

Register map, selected by a 2-bit address:
- 0: enable word. Bit 31 is the global gate. Bits 0..3 enable command ready, locality change, status valid and data available. Bits 5:4 hold the trigger type: 0 rising edge, 1 falling edge, 2 level high, 3 level low.
- 1: status word, with bits 0..3 in the same source order.
- 2: vector, in bits 7:0.
- 3: capability.

Writes are captured on the rising clock edge. Reads are combinational from the read address.

Top module: `tmi_irq_unit`

## Requirements
- R1: After reset the enable word reads 0x0000_0030 (level-low type, all enables off), the status word and the vector read 0, and irq_out is high (inactive for level low).
- R2: A status bit sets at the clock edge that samples its source condition going from 0 to 1. It stays set after the source drops, until it is cleared.
- R3: Status bit 3 (data available) sets only on a rising edge of the conjunction of ev_data_avail and ev_sts_valid. Data available alone sets nothing.
- R4: A write to address 1 clears every status bit whose write-data bit is 1 and leaves the others unchanged.
- R5: When a clear of a status bit and a new rising edge of its source fall in the same cycle, the bit ends set.
- R6: While enable bit 31 is 0, irq_out stays at the inactive value of the programmed type: 0 for types 0 and 2, 1 for types 1 and 3.
- R7: Only status bits whose enable bit (0..3) is 1 can activate irq_out.
- R8: In type 2 irq_out is 1, and in type 3 it is 0, for exactly as long as any enabled status bit is set under the global gate.
- R9: In type 0 irq_out pulses high, and in type 1 it pulses low, for exactly one cycle when the gated, masked status goes from zero to nonzero. New events while it is already nonzero give no further pulse.
- R10: Address 2 stores write-data bits 7:0 as the vector. It reads back with bits 31:8 as 0.
- R11: Address 3 always reads 0x0000_00FF: bits 3:0 mark all four sources and bits 7:4 all four trigger types as supported. Writes to it have no effect.
- R12: A write to address 0 replaces the global bit, the source enables and the whole trigger-type field at once. All other enable-word bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| ev_cmd_ready | input | 1 | Command-ready condition |
| ev_loc_change | input | 1 | Locality-change condition |
| ev_sts_valid | input | 1 | Status-valid condition |
| ev_data_avail | input | 1 | Data-available condition |
| irq_out | output | 1 | Interrupt pin shaped by the trigger type |

## Verification
Two functions share one cycle here: software clearing a status bit, and the hardware edge detector setting that same bit. The bench provokes this by raising the locality-change input in the same cycle that it writes a 1 to bit 1 of the status word. It also does so throughout a long stretch of mixed random writes and events. A behavioural reference model gives the set priority over the clear. It is compared against the read port and irq_out on every clock, and a directed readback confirms that the bit survives the collision.

// File: rtl/tmi_irq_pkg.sv
package tmi_irq_pkg;
  localparam int SRC_N = 4;

  // source bit order, shared by enable and status words
  localparam int SRC_CMD = 0;
  localparam int SRC_LOC = 1;
  localparam int SRC_STV = 2;
  localparam int SRC_DAV = 3;

  localparam logic [1:0] RA_ENABLE = 2'd0;
  localparam logic [1:0] RA_STATUS = 2'd1;
  localparam logic [1:0] RA_VECTOR = 2'd2;
  localparam logic [1:0] RA_CAPAB  = 2'd3;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_e;
endpackage

// File: rtl/tmi_src_latch.sv
module tmi_src_latch #(
  parameter int SRC_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] cond,
  input  logic [SRC_N-1:0] clr,
  output logic [SRC_N-1:0] stat
);
  logic [SRC_N-1:0] cond_q;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    logic rise;
    assign rise = cond[i] & ~cond_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cond_q[i] <= 1'b0;
        stat[i]   <= 1'b0;
      end else begin
        cond_q[i] <= cond[i];
        // a fresh edge outranks a simultaneous clear
        stat[i]   <= rise | (stat[i] & ~clr[i]);
      end
    end
  end
endmodule

// File: rtl/tmi_irq_regs.sv
module tmi_irq_regs
  import tmi_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              glb_en,
  output logic [SRC_N-1:0]  src_en,
  output trig_e             trig,
  output logic [VEC_W-1:0]  vec,
  output logic [SRC_N-1:0]  clr
);
  localparam int TRIG_LSB = SRC_N;
  localparam int GLB_BIT  = DATA_W - 1;

  logic wr_enable, wr_vector;
  logic unused_wbits;

  assign wr_enable = wr_en && (wr_addr == ADDR_W'(RA_ENABLE));
  assign wr_vector = wr_en && (wr_addr == ADDR_W'(RA_VECTOR));
  assign clr = (wr_en && (wr_addr == ADDR_W'(RA_STATUS))) ? wr_data[SRC_N-1:0] : '0;
  assign unused_wbits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
      src_en <= '0;
      trig   <= TRIG_LOW;
      vec    <= '0;
    end else begin
      if (wr_enable) begin
        glb_en <= wr_data[GLB_BIT];
        src_en <= wr_data[SRC_N-1:0];
        trig   <= trig_e'(wr_data[TRIG_LSB +: 2]);
      end
      if (wr_vector) vec <= wr_data[VEC_W-1:0];
    end
  end
endmodule

// File: rtl/tmi_irq_drive.sv
module tmi_irq_drive
  import tmi_irq_pkg::*;
#(
  parameter int SRC_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic [SRC_N-1:0] src_en,
  input  logic [SRC_N-1:0] stat,
  input  trig_e            trig,
  output logic             irq_out
);
  logic masked, masked_q, onset;

  assign masked = glb_en & (|(stat & src_en));
  assign onset  = masked & ~masked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) masked_q <= 1'b0;
    else        masked_q <= masked;
  end

  always_comb begin
    unique case (trig)
      TRIG_RISE: irq_out = onset;
      TRIG_FALL: irq_out = ~onset;
      TRIG_HIGH: irq_out = masked;
      default:   irq_out = ~masked;
    endcase
  end
endmodule

// File: rtl/tmi_irq_unit.sv
module tmi_irq_unit
  import tmi_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_cmd_ready,
  input  logic              ev_loc_change,
  input  logic              ev_sts_valid,
  input  logic              ev_data_avail,
  output logic              irq_out
);
  localparam logic [DATA_W-1:0] CAP_WORD = DATA_W'({4'hF, {SRC_N{1'b1}}});

  logic             glb_en;
  logic [SRC_N-1:0] src_en, clr, stat, cond;
  trig_e            trig;
  logic [VEC_W-1:0] vec;

  assign cond[SRC_CMD] = ev_cmd_ready;
  assign cond[SRC_LOC] = ev_loc_change;
  assign cond[SRC_STV] = ev_sts_valid;
  assign cond[SRC_DAV] = ev_data_avail & ev_sts_valid;

  tmi_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_waddr),
    .wr_data(reg_wdata), .glb_en(glb_en), .src_en(src_en), .trig(trig),
    .vec(vec), .clr(clr)
  );

  tmi_src_latch #(.SRC_N(SRC_N)) u_latch (
    .clk(clk), .rst_n(rst_n), .cond(cond), .clr(clr), .stat(stat)
  );

  tmi_irq_drive #(.SRC_N(SRC_N)) u_drive (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .src_en(src_en),
    .stat(stat), .trig(trig), .irq_out(irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_raddr)
      ADDR_W'(RA_ENABLE): begin
        reg_rdata[DATA_W-1]    = glb_en;
        reg_rdata[SRC_N +: 2]  = trig;
        reg_rdata[SRC_N-1:0]   = src_en;
      end
      ADDR_W'(RA_STATUS): reg_rdata[SRC_N-1:0] = stat;
      ADDR_W'(RA_VECTOR): reg_rdata[VEC_W-1:0] = vec;
      default:            reg_rdata = CAP_WORD;
    endcase
  end
endmodule

// File: rtl/tmi_irq_chk.sv
module tmi_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_raddr,
  input logic [31:0] reg_rdata,
  input logic        reg_wr,
  input logic [1:0]  reg_waddr,
  input logic [31:0] reg_wdata,
  input logic        ev_data_avail,
  input logic        ev_sts_valid,
  input logic        irq_out,
  input logic        glb_en,
  input logic [3:0]  src_en,
  input logic [1:0]  trig,
  input logic [3:0]  stat
);
  logic [3:0] keep;
  assign keep = stat & ~((reg_wr && reg_waddr == 2'd1) ? reg_wdata[3:0] : 4'h0);

  // R2: set bits not being cleared stay set
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(keep)) == $past(keep)));

  // R3: data-available status rises only after a qualified sample
  p_dav_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[3]) |-> $past(ev_data_avail && ev_sts_valid));

  // R6: global gate holds the pin inactive
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> (irq_out == trig[0]));

  // R8: level types follow pending enabled status
  p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig[1] && glb_en && |(stat & src_en)) |-> (irq_out == !trig[0]));

  // R9: an edge pulse lasts a single cycle
  p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig[1] && irq_out != trig[0]) |=> (trig[1] || irq_out == trig[0]));

  // R10: vector readback upper bits are zero
  p_vec_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr == 2'd2) |-> (reg_rdata[31:8] == 24'h0));
endmodule

bind tmi_irq_unit tmi_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
  .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
  .ev_data_avail(ev_data_avail), .ev_sts_valid(ev_sts_valid),
  .irq_out(irq_out), .glb_en(glb_en), .src_en(src_en), .trig(trig),
  .stat(stat)
);

// File: tb/tmi_irq_unit_tb.sv
module tmi_irq_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_waddr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [1:0] reg_raddr = 2'd0;
  logic [31:0] reg_rdata;
  logic ev_cmd = 1'b0, ev_loc = 1'b0, ev_sv = 1'b0, ev_dav = 1'b0;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmi_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ev_cmd_ready(ev_cmd), .ev_loc_change(ev_loc), .ev_sts_valid(ev_sv),
    .ev_data_avail(ev_dav), .irq_out(irq_out)
  );

  // behavioural reference model
  bit [31:0] m_en = 32'h30;
  bit [3:0]  m_st = 4'h0;
  bit [7:0]  m_vec = 8'h0;
  bit [3:0]  m_prevc = 4'h0;
  bit        m_prevm = 1'b0;

  function automatic bit m_masked();
    return m_en[31] && ((m_st & m_en[3:0]) != 4'h0);
  endfunction

  function automatic bit m_irq();
    bit mk = m_masked();
    case (m_en[5:4])
      2'd0: return mk && !m_prevm;
      2'd1: return !(mk && !m_prevm);
      2'd2: return mk;
      default: return !mk;
    endcase
  endfunction

  function automatic bit [31:0] m_read(input bit [1:0] a);
    case (a)
      2'd0: return m_en;
      2'd1: return {28'h0, m_st};
      2'd2: return {24'h0, m_vec};
      default: return 32'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 32'h30; m_st = 4'h0; m_vec = 8'h0; m_prevc = 4'h0; m_prevm = 1'b0;
    end else begin
      bit [3:0] c, clr;
      c = {ev_dav & ev_sv, ev_sv, ev_loc, ev_cmd};
      clr = (reg_wr && reg_waddr == 2'd1) ? reg_wdata[3:0] : 4'h0;
      m_prevm = m_masked();
      m_st = (m_st & ~clr) | (c & ~m_prevc);
      m_prevc = c;
      if (reg_wr && reg_waddr == 2'd0) m_en = reg_wdata & 32'h8000_003F;
      if (reg_wr && reg_waddr == 2'd2) m_vec = reg_wdata[7:0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock model comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 irq_out vs model", {31'h0, irq_out}, {31'h0, m_irq()});
      check("R4 reg_rdata vs model", reg_rdata, m_read(reg_raddr));
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_reg(input bit [1:0] a, input bit [31:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input bit [1:0] a, input bit [31:0] exp, input string tag);
    reg_raddr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic irq_chk(input bit exp, input string tag);
    #1;
    check(tag, {31'h0, irq_out}, {31'h0, exp});
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    rd_chk(2'd0, 32'h30, "R1 enable reset");
    rd_chk(2'd1, 32'h0, "R1 status reset");
    rd_chk(2'd2, 32'h0, "R1 vector reset");
    irq_chk(1'b1, "R1 irq idle level-low");
    // R11 capability
    rd_chk(2'd3, 32'hFF, "R11 capability");
    wr_reg(2'd3, 32'h0);
    rd_chk(2'd3, 32'hFF, "R11 capability after write");
    // R10 vector
    wr_reg(2'd2, 32'h1A5);
    rd_chk(2'd2, 32'hA5, "R10 vector");
    // R12 enable word
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_chk(2'd0, 32'h8000_003F, "R12 enable all ones");
    wr_reg(2'd0, 32'h20);
    rd_chk(2'd0, 32'h20, "R12 type replaced");
    // R2 sticky set
    ev_cmd = 1'b1; step(); ev_cmd = 1'b0; step();
    rd_chk(2'd1, 32'h1, "R2 sticky after drop");
    // R3 qualification
    ev_dav = 1'b1; step(); step();
    rd_chk(2'd1, 32'h1, "R3 data alone ignored");
    ev_sv = 1'b1; step(); step();
    rd_chk(2'd1, 32'hD, "R3 qualified data");
    ev_sv = 1'b0; ev_dav = 1'b0; step();
    // R4 write-one clear
    wr_reg(2'd1, 32'h1);
    rd_chk(2'd1, 32'hC, "R4 clear bit0 only");
    wr_reg(2'd1, 32'hC);
    rd_chk(2'd1, 32'h0, "R4 clear rest");
    // R5 collision: clear and set same cycle
    ev_loc = 1'b1; reg_wr = 1'b1; reg_waddr = 2'd1; reg_wdata = 32'h2;
    step();
    reg_wr = 1'b0; ev_loc = 1'b0; step();
    rd_chk(2'd1, 32'h2, "R5 set wins");
    // R6 global gate
    wr_reg(2'd0, 32'h2F);
    irq_chk(1'b0, "R6 gated off");
    // R7 per-source mask
    wr_reg(2'd0, 32'h8000_0021);
    irq_chk(1'b0, "R7 masked source");
    wr_reg(2'd0, 32'h8000_0022);
    irq_chk(1'b1, "R7 enabled source");
    // R8 level low
    wr_reg(2'd0, 32'h8000_0032);
    irq_chk(1'b0, "R8 level low active");
    wr_reg(2'd1, 32'h2);
    irq_chk(1'b1, "R8 level low released");
    // R9 rising edge
    wr_reg(2'd0, 32'h8000_0002);
    irq_chk(1'b0, "R9 rise idle");
    ev_loc = 1'b1; step(); ev_loc = 1'b0;
    irq_chk(1'b1, "R9 rise pulse");
    step();
    irq_chk(1'b0, "R9 rise pulse ends");
    // R9 falling edge and no repeat pulse
    wr_reg(2'd1, 32'h2);
    wr_reg(2'd0, 32'h8000_0012);
    irq_chk(1'b1, "R9 fall idle");
    ev_loc = 1'b1; step(); ev_loc = 1'b0;
    irq_chk(1'b0, "R9 fall pulse");
    step();
    irq_chk(1'b1, "R9 fall pulse ends");
    wr_reg(2'd0, 32'h8000_0013);
    ev_cmd = 1'b1; step(); ev_cmd = 1'b0;
    irq_chk(1'b1, "R9 no second pulse");
    step();
    // mixed traffic, judged by the model every clock
    for (int i = 0; i < 2000; i++) begin
      bit [31:0] r = $urandom;
      ev_cmd = r[0]; ev_loc = r[1]; ev_sv = r[2]; ev_dav = r[3];
      reg_wr = (r[7:5] == 3'd0);
      reg_waddr = r[9:8];
      reg_wdata = (r[9:8] == 2'd0) ? {r[10], 25'h0, r[17:12]} : {$urandom};
      reg_raddr = r[19:18];
      step();
    end
    reg_wr = 1'b0;
    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule